// File: doc/BRIEF.md
# Processor Status Word and Interrupt Gate

This block holds the processor status word of a small microcontroller core and decides whether a pending maskable interrupt is taken. The ALU result path updates the four arithmetic flags: carry, zero, sign and overflow. The core can also load the whole flag word in one write. The word also stores a debug flag, a register bank select, a stack pointer select, an interrupt enable and a 3-bit processor priority level. The bank and stack selects are brought out as separate pins so that the register file and the stack logic can use them directly.

A maskable request is accepted in the same cycle that it is presented, but only when the enable flag is set and the request priority is strictly above the current level. When a request is accepted, the block shows the flag word from before acceptance so that the caller can save it. On the next edge it clears the enable and stack select flags and loads the request priority as the new level. A software interrupt clears the stack select only for interrupt numbers 1 to 31. A 20-bit table base register can be written to move the vector table. The block forms each vector address from that base and the interrupt number.

Top module: `cpu_status_reg`

## Requirements
- R1: After reset `flags_o` is 0x0000, `intb_o` is 0, and `irq_ack_o` is 0.
- R2: When `alu_we_i` is high and neither an acceptance nor a flag write happens, the next flag word has C=`alu_carry_i`, Z=1 exactly when `alu_res_i` is zero, S=the top bit of `alu_res_i` and O=`alu_ovf_i`. D, B, I, U and the level are left unchanged.
- R3: A flag write with `wr_en_i` loads the word with C at bit 0, D at bit 1, Z at bit 2, S at bit 3, B at bit 4, O at bit 5, I at bit 6, U at bit 7 and the level in bits 14:12. Every other bit reads as 0.
- R4: `bank_sel_o` follows flag B and `usp_sel_o` follows flag U.
- R5: `irq_ack_o` is 1 in the same cycle only when `irq_req_i` is 1, I is 1 and `irq_prio_i` is strictly greater than the level. Equal priority is not accepted.
- R6: During the acceptance cycle `flags_o` still shows the old word. On the next edge I and U are cleared, the level becomes `irq_prio_i`, and C, D, Z, S, B and O are kept.
- R7: `swi_i` clears U when `swi_num_i` is 1 to 31. Numbers 0 and 32 and above leave U unchanged. A software interrupt changes no other flag.
- R8: `vec_addr_o` is `intb_o` + 4·n modulo 2^20. n is `irq_num_i` while `irq_ack_o` is 1 and `swi_num_i` otherwise.
- R9: `intb_we_i` loads `intb_wdata_i` into the table base register on the next edge.
- R10: In one cycle, an acceptance takes precedence over a flag write. A flag write takes precedence over ALU updates and over the software-interrupt clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alu_we_i | input | 1 | Apply ALU flag results |
| alu_res_i | input | 16 | ALU result |
| alu_carry_i | input | 1 | Carry, borrow or shifted-out bit |
| alu_ovf_i | input | 1 | Overflow from ALU |
| wr_en_i | input | 1 | Whole flag word write |
| wr_data_i | input | 16 | Flag word write data |
| irq_req_i | input | 1 | Maskable request pending |
| irq_prio_i | input | 3 | Request priority |
| irq_num_i | input | 6 | Request vector number |
| irq_ack_o | output | 1 | Request accepted this cycle |
| swi_i | input | 1 | Software interrupt executed |
| swi_num_i | input | 6 | Software interrupt number |
| intb_we_i | input | 1 | Table base write |
| intb_wdata_i | input | 20 | Table base write data |
| intb_o | output | 20 | Table base register |
| vec_addr_o | output | 20 | Vector address |
| flags_o | output | 16 | Current (pre-acceptance) flag word |
| bank_sel_o | output | 1 | Register bank select |
| usp_sel_o | output | 1 | User stack pointer select |

## Verification
The assertions assume that the caller keeps `irq_prio_i` steady and valid for the whole cycle in which it raises `irq_req_i`. They also assume that a software interrupt and an accepted hardware interrupt are never meant to act in the same cycle. The stimulus changes inputs only at falling edges and samples the combinational acceptance and vector outputs before the next rising edge. It raises `swi_i` only in cycles with no pending request. The precedence case drives a flag write and an ALU update together, which is a legal overlap.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int FLAG_W = 16;
  localparam int IPL_W  = 3;

  typedef struct packed {
    logic [IPL_W-1:0] ipl;
    logic u, i, o, b, s, z, d, c;
  } psw_t;

  function automatic logic [FLAG_W-1:0] psw_pack(psw_t p);
    logic [FLAG_W-1:0] w;
    w = '0;
    w[0] = p.c; w[1] = p.d; w[2] = p.z; w[3] = p.s;
    w[4] = p.b; w[5] = p.o; w[6] = p.i; w[7] = p.u;
    w[14:12] = p.ipl;
    return w;
  endfunction

  function automatic psw_t psw_unpack(logic [FLAG_W-1:0] w);
    psw_t p;
    p.c = w[0]; p.d = w[1]; p.z = w[2]; p.s = w[3];
    p.b = w[4]; p.o = w[5]; p.i = w[6]; p.u = w[7];
    p.ipl = w[14:12];
    return p;
  endfunction
endpackage

// File: rtl/psw_alu_flags.sv
module psw_alu_flags #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] res_i,
  output logic              zero_o,
  output logic              neg_o
);
  assign zero_o = (res_i == '0);
  assign neg_o  = res_i[DATA_W-1];
endmodule

// File: rtl/psw_irq_gate.sv
module psw_irq_gate #(
  parameter int PRIO_W = 3
) (
  input  logic              req_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic              ie_i,
  input  logic [PRIO_W-1:0] ipl_i,
  output logic              ack_o
);
  // strict compare: equal level stays masked
  assign ack_o = req_i && ie_i && (prio_i > ipl_i);
endmodule

// File: rtl/psw_vec_gen.sv
module psw_vec_gen #(
  parameter int ADDR_W = 20,
  parameter int NUM_W  = 6
) (
  input  logic [ADDR_W-1:0] intb_i,
  input  logic              sel_hw_i,
  input  logic [NUM_W-1:0]  hw_num_i,
  input  logic [NUM_W-1:0]  sw_num_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sw_clr_u_o
);
  localparam int SW_CLR_MAX = 31;

  logic [NUM_W-1:0]  num;
  logic [ADDR_W-1:0] offs;

  assign num        = sel_hw_i ? hw_num_i : sw_num_i;
  assign offs       = ADDR_W'(num) << 2;
  assign addr_o     = intb_i + offs;
  assign sw_clr_u_o = (sw_num_i != '0) && (32'(sw_num_i) <= SW_CLR_MAX);

  always_comb begin
    AST_VEC_ALIGN: assert (addr_o[1:0] == intb_i[1:0]); // R8
  end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import psw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20,
  parameter int NUM_W  = 6,
  parameter int PRIO_W = IPL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alu_we_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic              alu_carry_i,
  input  logic              alu_ovf_i,
  input  logic              wr_en_i,
  input  logic [FLAG_W-1:0] wr_data_i,
  input  logic              irq_req_i,
  input  logic [PRIO_W-1:0] irq_prio_i,
  input  logic [NUM_W-1:0]  irq_num_i,
  output logic              irq_ack_o,
  input  logic              swi_i,
  input  logic [NUM_W-1:0]  swi_num_i,
  input  logic              intb_we_i,
  input  logic [ADDR_W-1:0] intb_wdata_i,
  output logic [ADDR_W-1:0] intb_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              bank_sel_o,
  output logic              usp_sel_o
);
  psw_t              psw_q;
  logic [ADDR_W-1:0] intb_q;
  logic              alu_zero, alu_neg, sw_clr_u;

  psw_alu_flags #(.DATA_W(DATA_W)) u_alu_flags (
    .res_i (alu_res_i),
    .zero_o(alu_zero),
    .neg_o (alu_neg)
  );

  psw_irq_gate #(.PRIO_W(PRIO_W)) u_irq_gate (
    .req_i (irq_req_i),
    .prio_i(irq_prio_i),
    .ie_i  (psw_q.i),
    .ipl_i (psw_q.ipl),
    .ack_o (irq_ack_o)
  );

  psw_vec_gen #(.ADDR_W(ADDR_W), .NUM_W(NUM_W)) u_vec_gen (
    .intb_i    (intb_q),
    .sel_hw_i  (irq_ack_o),
    .hw_num_i  (irq_num_i),
    .sw_num_i  (swi_num_i),
    .addr_o    (vec_addr_o),
    .sw_clr_u_o(sw_clr_u)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_q <= '0;
    end else if (irq_ack_o) begin
      psw_q.i   <= 1'b0;
      psw_q.u   <= 1'b0;
      psw_q.ipl <= irq_prio_i;
    end else if (wr_en_i) begin
      psw_q <= psw_unpack(wr_data_i);
    end else begin
      if (alu_we_i) begin
        psw_q.c <= alu_carry_i;
        psw_q.z <= alu_zero;
        psw_q.s <= alu_neg;
        psw_q.o <= alu_ovf_i;
      end
      if (swi_i && sw_clr_u) psw_q.u <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        intb_q <= '0;
    else if (intb_we_i) intb_q <= intb_wdata_i;
  end

  assign flags_o    = psw_pack(psw_q);
  assign intb_o     = intb_q;
  assign bank_sel_o = psw_q.b;
  assign usp_sel_o  = psw_q.u;

  AST_ACK_ABOVE_IPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> (psw_q.i && irq_prio_i > psw_q.ipl)); // R5
  AST_ACK_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> (!psw_q.i && !psw_q.u)); // R6
  AST_ACK_LOADS_IPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> (psw_q.ipl == $past(irq_prio_i))); // R6
  AST_ACK_KEEPS_ARITH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> ($stable(psw_q.c) && $stable(psw_q.z) && $stable(psw_q.b))); // R10
  AST_ALU_KEEPS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_we_i && !irq_ack_o && !wr_en_i) |=>
      ($stable(psw_q.b) && $stable(psw_q.d) && $stable(psw_q.i) && $stable(psw_q.ipl))); // R2
  AST_SWI_ONLY_U: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swi_i && !irq_ack_o && !wr_en_i) |=>
      ($stable(psw_q.b) && $stable(psw_q.i) && $stable(psw_q.ipl))); // R7
endmodule

// File: tb/cpu_status_reg_tb.sv
module cpu_status_reg_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alu_we_i = 1'b0;
  logic [15:0] alu_res_i = '0;
  logic        alu_carry_i = 1'b0, alu_ovf_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        irq_req_i = 1'b0;
  logic [2:0]  irq_prio_i = '0;
  logic [5:0]  irq_num_i = '0;
  logic        irq_ack_o;
  logic        swi_i = 1'b0;
  logic [5:0]  swi_num_i = '0;
  logic        intb_we_i = 1'b0;
  logic [19:0] intb_wdata_i = '0;
  logic [19:0] intb_o, vec_addr_o;
  logic [15:0] flags_o;
  logic        bank_sel_o, usp_sel_o;

  int total = 0, bad = 0;

  always #5 clk_i = ~clk_i;

  cpu_status_reg u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr_flags(logic [15:0] w);
    wr_en_i = 1'b1; wr_data_i = w;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 flags", flags_o, 16'h0000);
    chk("R1 intb", intb_o, 20'h0);
    chk("R1 ack", irq_ack_o, 1'b0);
  endtask

  task automatic t_write();
    wr_flags(16'hFFFF);
    chk("R3 mask", flags_o, 16'h70FF);
    chk("R4 bank", bank_sel_o, 1'b1);
    chk("R4 usp", usp_sel_o, 1'b1);
    wr_flags(16'h2010);
    chk("R3 layout", flags_o, 16'h2010);
    chk("R4 usp low", usp_sel_o, 1'b0);
  endtask

  task automatic t_alu();
    wr_flags(16'h50D2); // D,B?no: bits 1,4,6,7 set, ipl 5
    alu_we_i = 1'b1; alu_res_i = 16'h0000; alu_carry_i = 1'b1; alu_ovf_i = 1'b0;
    step();
    chk("R2 zero+carry", flags_o, 16'h50D2 | 16'h0005);
    alu_res_i = 16'h8001; alu_carry_i = 1'b0; alu_ovf_i = 1'b1;
    step();
    chk("R2 sign+ovf", flags_o, 16'h50D2 | 16'h0028);
    alu_res_i = 16'h0123; alu_ovf_i = 1'b0;
    step();
    chk("R2 plain", flags_o, 16'h50D2);
    alu_we_i = 1'b0;
  endtask

  task automatic t_accept();
    wr_flags(16'h3095); // C,Z,B,U set, I=0, ipl 3
    irq_req_i = 1'b1; irq_prio_i = 3'd7; irq_num_i = 6'd9;
    #1 chk("R5 ie off", irq_ack_o, 1'b0);
    irq_req_i = 1'b0;
    wr_flags(16'h30D5); // I set, ipl 3
    irq_req_i = 1'b1; irq_prio_i = 3'd3;
    #1 chk("R5 equal", irq_ack_o, 1'b0);
    irq_prio_i = 3'd2;
    #1 chk("R5 lower", irq_ack_o, 1'b0);
    irq_prio_i = 3'd4;
    #1 chk("R5 higher", irq_ack_o, 1'b1);
    chk("R6 old word", flags_o, 16'h30D5);
    wr_en_i = 1'b1; wr_data_i = 16'h0000; alu_we_i = 1'b1; alu_res_i = 16'h0001;
    step();
    wr_en_i = 1'b0; alu_we_i = 1'b0; irq_req_i = 1'b0;
    chk("R6 R10 after ack", flags_o, 16'h4015);
    chk("R6 usp", usp_sel_o, 1'b0);
  endtask

  task automatic t_vector();
    intb_we_i = 1'b1; intb_wdata_i = 20'hFFFF0;
    step();
    intb_we_i = 1'b0;
    chk("R9 intb", intb_o, 20'hFFFF0);
    swi_num_i = 6'd5;
    #1 chk("R8 wrap", vec_addr_o, 20'h00004);
    wr_flags(16'h1040); // I set, ipl 1
    irq_req_i = 1'b1; irq_prio_i = 3'd6; irq_num_i = 6'd63;
    #1 chk("R8 hw num", vec_addr_o, 20'h000EC);
    @(negedge clk_i); // let ack happen so next state settles
    irq_req_i = 1'b0;
    chk("R6 ipl", flags_o, 16'h6000);
  endtask

  task automatic t_swi();
    logic [5:0] nums [4] = '{6'd0, 6'd32, 6'd31, 6'd1};
    logic       exp_u [4] = '{1'b1, 1'b1, 1'b0, 1'b0};
    for (int k = 0; k < 4; k++) begin
      wr_flags(16'h30D0);
      swi_i = 1'b1; swi_num_i = nums[k];
      step();
      swi_i = 1'b0;
      chk($sformatf("R7 swi %0d usp", nums[k]), usp_sel_o, exp_u[k]);
      chk($sformatf("R7 swi %0d rest", nums[k]), flags_o & 16'hFF7F, 16'h3050);
    end
    wr_flags(16'h0080);
    swi_i = 1'b1; swi_num_i = 6'd4; wr_en_i = 1'b1; wr_data_i = 16'h0080;
    step();
    swi_i = 1'b0; wr_en_i = 1'b0;
    chk("R10 write over swi", flags_o, 16'h0080);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_write();
    t_alu();
    t_accept();
    t_vector();
    t_swi();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule